// File: doc/BRIEF.md
# Timestamp Capture Unit

The unit watches eight external capture inputs and, when one of them changes in the direction it is watching for, copies the current value of a free-running 64-bit timer into a capture slot. Inputs 0 to 5 react only to rising edges and each owns one slot. Inputs 6 and 7 react to both edges and each owns two slots, one for the rising edge and one for the falling edge. That gives ten slots in total. Each slot has a sticky valid bit. Software clears a valid bit by writing 1 to it. Software reads a slot by placing its index on a select port.

Each input is chosen per bit to be synchronous or asynchronous. In synchronous mode the input passes through a two-flop synchronizer before edge detection, so the captured value is two timer ticks later than in asynchronous mode. In asynchronous mode the edge detector samples the pin directly at the clock edge. Each input has its own enable. A single registered event output pulses whenever at least one capture is committed, for use as an interrupt source.

Edge detection is a two-state machine per input. The state `LVL_LOW` moves to `LVL_HIGH` on a rising transition and reports a rising edge. `LVL_HIGH` moves back to `LVL_LOW` on a falling transition and reports a falling edge, but only for the dual-edge inputs. Both states loop on themselves while the level is unchanged. The machine keeps tracking the level while its input is disabled.

Top module: `tstamp_capture`

## Requirements
- R1: After reset every valid bit is 0, the event output is 0 and every slot reads 0.
- R2: For inputs 0 to 5, a rising edge captures into slot index equal to the input number. A falling edge on these inputs changes no valid bit and raises no event.
- R3: For input 6, the rising edge is captured into slot 6 and the falling edge into slot 7. For input 7, the rising edge is captured into slot 8 and the falling edge into slot 9.
- R4: With the input's mode bit at 0 (asynchronous), an input that goes high before clock edge k stores the timer value sampled at edge k. Valid and the event are visible after edge k.
- R5: With the input's mode bit at 1 (synchronous), the same change is committed at edge k+2 and stores the timer value sampled there.
- R6: Valid bits are sticky. A one-cycle pulse on bit n of the clear port clears only valid bit n.
- R7: When a capture and a clear hit the same slot in the same cycle, the valid bit ends at 1.
- R8: While an input's enable bit is 0 it neither captures nor raises the event. Enabling an input while its level is already high produces no capture.
- R9: The event output is high for exactly the cycle after each edge at which one or more captures were committed. It stays high across consecutive commit edges.
- R10: A new capture overwrites the slot's earlier value.
- R11: A select value of 10 to 15 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| timer_val | input | 64 | Current timer value to be latched |
| cap_in | input | 8 | Capture input pins |
| chan_en | input | 8 | Per-input enable |
| sync_mode | input | 8 | Per-input mode: 1 synchronous, 0 asynchronous |
| clr_valid | input | 10 | Write-1-to-clear pulses, one per slot |
| rd_sel | input | 4 | Slot index to read |
| rd_data | output | 64 | Contents of the selected slot |
| valid | output | 10 | Sticky valid bit per slot |
| cap_event | output | 1 | One-cycle pulse after any committed capture |

## Verification
The hardest conditions to reach from the ports are those where two things act on one slot or one edge detector in the same cycle. One is a capture and a clear landing together. Another is an input whose enable rises while its pin is already high, so the level is set but no edge must be seen. The bench reaches these by scheduling pin changes, clear pulses and enable changes on the same falling clock edge. It then reads the valid bits on the next falling edge. A full sweep over all eight inputs in both modes checks the latency difference arithmetically against a bench-owned timer.

// File: rtl/tsc_pkg.sv
`timescale 1ns/1ps
package tsc_pkg;

    typedef enum logic {
        LVL_LOW  = 1'b0,
        LVL_HIGH = 1'b1
    } lvl_state_e;

    // Slot index holding the rising-edge capture of input idx.
    // Rise-only inputs come first, one slot each; dual inputs take two.
    function automatic int rise_slot(input int idx, input int n_in, input int n_dual);
        int n_single;
        n_single = n_in - n_dual;
        if (idx < n_single)
            return idx;
        return n_single + 2 * (idx - n_single);
    endfunction

endpackage

// File: rtl/tsc_sync.sv
`timescale 1ns/1ps
module tsc_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic din_i,
    input  logic sync_en_i,
    output logic dout_o
);
    logic s1_q, s2_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q <= 1'b0;
            s2_q <= 1'b0;
        end else begin
            s1_q <= din_i;
            s2_q <= s1_q;
        end
    end

    assign dout_o = sync_en_i ? s2_q : din_i;

endmodule

// File: rtl/tsc_edge_fsm.sv
`timescale 1ns/1ps
module tsc_edge_fsm #(
    parameter bit DUAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_i,
    output logic rise_o,
    output logic fall_o
);
    import tsc_pkg::*;

    lvl_state_e st_q, st_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= LVL_LOW;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            LVL_LOW:  if (lvl_i)  st_d = LVL_HIGH;
            LVL_HIGH: if (!lvl_i) st_d = LVL_LOW;
            default:  st_d = LVL_LOW;
        endcase
    end

    always_comb begin
        rise_o = 1'b0;
        fall_o = 1'b0;
        unique case (st_q)
            LVL_LOW:  rise_o = lvl_i;
            LVL_HIGH: fall_o = DUAL & ~lvl_i;
            default:  ;
        endcase
    end

    // An edge is reported once per transition, never on two cycles in a row.
    assert_single_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o);
    assert_single_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
        fall_o |=> !fall_o);

endmodule

// File: rtl/tsc_capture_bank.sv
`timescale 1ns/1ps
module tsc_capture_bank #(
    parameter int TW   = 64,
    parameter int NREG = 10,
    parameter int SW   = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [TW-1:0]   timer_i,
    input  logic [NREG-1:0] set_i,
    input  logic [NREG-1:0] clr_i,
    input  logic [SW-1:0]   sel_i,
    output logic [NREG-1:0] valid_o,
    output logic [TW-1:0]   data_o
);
    logic [TW-1:0] slot_q [NREG];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < NREG; k++) slot_q[k] <= '0;
            valid_o <= '0;
        end else begin
            for (int k = 0; k < NREG; k++) begin
                if (set_i[k]) begin
                    slot_q[k]  <= timer_i;
                    valid_o[k] <= 1'b1;
                end else if (clr_i[k]) begin
                    valid_o[k] <= 1'b0;
                end
            end
        end
    end

    always_comb begin
        data_o = '0;
        for (int k = 0; k < NREG; k++)
            if (sel_i == SW'(k)) data_o = slot_q[k];
    end

    genvar g;
    generate
        for (g = 0; g < NREG; g++) begin : g_chk
            assert_hold_without_commit_R8: assert property (@(posedge clk) disable iff (!rst_n)
                !set_i[g] |=> $stable(slot_q[g]));
            assert_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
                set_i[g] |=> valid_o[g]);
            assert_clear_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
                (clr_i[g] && !set_i[g]) |=> !valid_o[g]);
        end
    endgenerate

endmodule

// File: rtl/tstamp_capture.sv
`timescale 1ns/1ps
module tstamp_capture #(
    parameter int TW       = 64,
    parameter int NUM_IN   = 8,
    parameter int NUM_DUAL = 2
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic [TW-1:0]                         timer_val,
    input  logic [NUM_IN-1:0]                     cap_in,
    input  logic [NUM_IN-1:0]                     chan_en,
    input  logic [NUM_IN-1:0]                     sync_mode,
    input  logic [NUM_IN+NUM_DUAL-1:0]            clr_valid,
    input  logic [$clog2(NUM_IN+NUM_DUAL)-1:0]    rd_sel,
    output logic [TW-1:0]                         rd_data,
    output logic [NUM_IN+NUM_DUAL-1:0]            valid,
    output logic                                  cap_event
);
    localparam int NUM_REG  = NUM_IN + NUM_DUAL;
    localparam int SEL_W    = $clog2(NUM_REG);
    localparam int NUM_SNGL = NUM_IN - NUM_DUAL;

    logic [NUM_IN-1:0]  lvl_w;
    logic [NUM_IN-1:0]  rise_w;
    logic [NUM_IN-1:0]  fall_w;
    logic [NUM_REG-1:0] set_v;
    logic [2*NUM_IN-1:0] hit_v;

    genvar i;
    generate
        for (i = 0; i < NUM_IN; i++) begin : g_in
            localparam int  RS     = tsc_pkg::rise_slot(i, NUM_IN, NUM_DUAL);
            localparam bit  IS_DUAL = (i >= NUM_SNGL);

            tsc_sync u_sync (
                .clk      (clk),
                .rst_n    (rst_n),
                .din_i    (cap_in[i]),
                .sync_en_i(sync_mode[i]),
                .dout_o   (lvl_w[i])
            );

            tsc_edge_fsm #(.DUAL(IS_DUAL)) u_fsm (
                .clk   (clk),
                .rst_n (rst_n),
                .lvl_i (lvl_w[i]),
                .rise_o(rise_w[i]),
                .fall_o(fall_w[i])
            );

            assign hit_v[2*i]   = chan_en[i] & rise_w[i];
            assign hit_v[2*i+1] = chan_en[i] & fall_w[i];
            assign set_v[RS]    = hit_v[2*i];

            if (IS_DUAL) begin : g_dual
                assign set_v[RS+1] = hit_v[2*i+1];
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cap_event <= 1'b0;
        else        cap_event <= |hit_v;
    end

    tsc_capture_bank #(.TW(TW), .NREG(NUM_REG), .SW(SEL_W)) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .timer_i(timer_val),
        .set_i  (set_v),
        .clr_i  (clr_valid),
        .sel_i  (rd_sel),
        .valid_o(valid),
        .data_o (rd_data)
    );

    assert_event_follows_commit_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_v) |=> cap_event);
    assert_event_has_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cap_event |-> (|valid));
    assert_disabled_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_en == '0) |=> !cap_event);

endmodule

// File: tb/tstamp_capture_tb.sv
`timescale 1ns/1ps
module tstamp_capture_tb;
    localparam logic [63:0] BASE = 64'hC0DE_0000_FFFF_FF00;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] timer;
    logic [7:0]  cap_in = '0, chan_en = '1, sync_mode = '0;
    logic [9:0]  clr_valid = '0;
    logic [3:0]  rd_sel = '0;
    logic [63:0] rd_data;
    logic [9:0]  valid;
    logic        cap_event;

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    always @(posedge clk) begin
        if (!rst_n) timer <= BASE;
        else        timer <= timer + 64'd1;
    end

    tstamp_capture u_dut (
        .clk(clk), .rst_n(rst_n), .timer_val(timer), .cap_in(cap_in),
        .chan_en(chan_en), .sync_mode(sync_mode), .clr_valid(clr_valid),
        .rd_sel(rd_sel), .rd_data(rd_data), .valid(valid), .cap_event(cap_event)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic rd(input int idx, output logic [63:0] v);
        rd_sel = idx[3:0];
        #1;
        v = rd_data;
    endtask

    task automatic clear_all();
        clr_valid = '1;
        step(1);
        clr_valid = '0;
        step(1);
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [63:0] v, t0, t1;
        step(3);
        rst_n = 1'b1;
        step(1);

        // R1: reset state
        chk("R1 valid", {54'd0, valid}, 64'd0);
        chk("R1 event", {63'd0, cap_event}, 64'd0);
        for (int k = 0; k < 10; k++) begin
            rd(k, v);
            chk("R1 slot", v, 64'd0);
        end

        // Sweep every input in both modes (R2 R3 R4 R5 R6 R9)
        for (int mode = 0; mode < 2; mode++) begin
            for (int i = 0; i < 8; i++) begin
                int lat, rs;
                lat = (mode != 0) ? 3 : 1;
                rs  = (i < 6) ? i : 6 + 2 * (i - 6);
                sync_mode = {8{mode[0]}};
                step(3);
                t0 = timer;
                cap_in[i] = 1'b1;
                step(lat);
                rd(rs, v);
                chk(mode != 0 ? "R5 rise value" : "R4 rise value", v, t0 + 64'(lat - 1));
                chk(i < 6 ? "R2 rise slot" : "R3 rise slot", {54'd0, valid}, 64'd1 << rs);
                chk("R9 event high", {63'd0, cap_event}, 64'd1);
                step(1);
                chk("R9 event one cycle", {63'd0, cap_event}, 64'd0);
                t1 = timer;
                cap_in[i] = 1'b0;
                step(lat);
                if (i >= 6) begin
                    rd(rs + 1, v);
                    chk(mode != 0 ? "R3 R5 fall value" : "R3 R4 fall value", v, t1 + 64'(lat - 1));
                    chk("R3 fall slot", {54'd0, valid}, 64'd3 << rs);
                    chk("R3 fall event", {63'd0, cap_event}, 64'd1);
                end else begin
                    chk("R2 fall ignored valid", {54'd0, valid}, 64'd1 << rs);
                    chk("R2 fall ignored event", {63'd0, cap_event}, 64'd0);
                end
                clear_all();
                chk("R6 cleared", {54'd0, valid}, 64'd0);
            end
        end

        sync_mode = '0;
        step(2);

        // R7: capture and clear together on slot 0
        cap_in[0] = 1'b1;
        clr_valid[0] = 1'b1;
        step(1);
        clr_valid = '0;
        chk("R7 set beats clear", {63'd0, valid[0]}, 64'd1);
        cap_in[0] = 1'b0;
        step(1);
        clear_all();

        // R6: partial clear
        cap_in[1] = 1'b1;
        cap_in[2] = 1'b1;
        step(1);
        chk("R9 event two captures", {63'd0, cap_event}, 64'd1);
        clr_valid = 10'b00_0000_0010;
        step(1);
        clr_valid = '0;
        chk("R6 partial clear", {54'd0, valid}, 64'h4);
        cap_in[1] = 1'b0;
        cap_in[2] = 1'b0;
        step(1);
        clear_all();

        // R9: consecutive commit edges
        cap_in[4] = 1'b1;
        step(1);
        chk("R9 first", {63'd0, cap_event}, 64'd1);
        cap_in[5] = 1'b1;
        step(1);
        chk("R9 back to back", {63'd0, cap_event}, 64'd1);
        step(1);
        chk("R9 drop", {63'd0, cap_event}, 64'd0);
        cap_in[4] = 1'b0;
        cap_in[5] = 1'b0;
        step(1);
        clear_all();

        // R10: overwrite
        t0 = timer;
        cap_in[0] = 1'b1;
        step(1);
        cap_in[0] = 1'b0;
        step(5);
        t1 = timer;
        cap_in[0] = 1'b1;
        step(1);
        rd(0, v);
        chk("R10 overwrite", v, t1);
        cap_in[0] = 1'b0;
        step(1);
        clear_all();

        // R8: disabled input, then enable while high
        chan_en[3] = 1'b0;
        cap_in[3] = 1'b1;
        for (int c = 0; c < 4; c++) begin
            step(1);
            chk("R8 disabled no event", {63'd0, cap_event}, 64'd0);
        end
        chk("R8 disabled no valid", {63'd0, valid[3]}, 64'd0);
        chan_en[3] = 1'b1;
        step(2);
        chk("R8 enable while high", {63'd0, valid[3]}, 64'd0);
        chk("R8 enable while high event", {63'd0, cap_event}, 64'd0);
        cap_in[3] = 1'b0;
        step(1);
        t0 = timer;
        cap_in[3] = 1'b1;
        step(1);
        rd(3, v);
        chk("R8 enabled capture", v, t0);
        chk("R8 enabled valid", {63'd0, valid[3]}, 64'd1);
        cap_in[3] = 1'b0;
        step(1);

        // R11: out-of-range select
        rd(10, v);
        chk("R11 sel 10", v, 64'd0);
        rd(15, v);
        chk("R11 sel 15", v, 64'd0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule